// File: doc/BRIEF.md
# DMA Channel Completion Interrupt Bank

This block gathers completion events from a group of DMA channels and folds them into one active-high interrupt line. Every channel raises three kinds of event pulse: half of a transfer moved, one descriptor finished, and the whole descriptor chain finished. Each pulse is caught in a sticky status bit. A matching enable bit decides whether that pending status may drive the interrupt.

Software uses a plain 32-bit register bus to program the enable words and to read and clear the status words. Each channel takes a four-bit slot, and eight channels share one word. Status is cleared by writing ones, so a handler can write back the value it just read and acknowledge exactly those events. The event sources and any bus protocol bridging are outside this block.

Top module: `irq_event_bank`

## Requirements
- R1: While reset is held and on the first cycle after it, every enable and status bit is zero, irq is low and every register reads zero.
- R2: Channel n occupies register n/8 at bits [4*(n%8)+3 : 4*(n%8)]. Slot bit 0 is half-transfer, bit 1 is descriptor done and bit 2 is chain done. Enable word k is at byte offset 4*k and status word k is at byte offset 0x10 + 4*k.
- R3: An event pulse sets its status bit on the clock edge where the pulse is sampled, whether or not the matching enable bit is set. The bit can be read back from the next cycle on.
- R4: A write to a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: When an event pulse and a clearing write reach the same status bit on the same edge, the bit stays set.
- R6: irq is a register equal to the OR over all (status AND enable) bits of the previous cycle. It rises one cycle after an enabled status bit sets and falls one cycle after the last enabled pending bit clears.
- R7: After zero is written to every enable word, irq is low from the following cycle on and stays low while new events arrive.
- R8: Bit 3 of every slot, and every slot of a channel number at or above NUM_CH, reads as zero and keeps no written value.
- R9: Status bits can never be set by a write. A write whose address is not word aligned, or that falls on a word with no channels or outside the map, changes nothing.
- R10: An enable word reads back the value last written to it, limited to the bits of channels that exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ev_half | input | NUM_CH | Per-channel half-transfer event pulse |
| ev_desc | input | NUM_CH | Per-channel descriptor-done event pulse |
| ev_list | input | NUM_CH | Per-channel chain-done event pulse |
| irq | output | 1 | Registered interrupt level, active high |

## Verification
The bench builds the bank with NUM_CH set to 12, so the second word holds only four channels. This makes the empty upper slots of a partly filled word observable, and it leaves an enable and status word pair with no channels in the map, which lets the bench check that accesses to them are ignored. The default ADDR_W of 8 keeps addresses above the map reachable, so out-of-map writes can be tried. Channels in both words are driven so that the slot position and the word index are each checked on their own.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int BUS_W       = 32;
    localparam int SLOT_W      = 4;
    localparam int EVT_W       = 3;
    localparam int CH_PER_WORD = BUS_W / SLOT_W;
    localparam int MAX_WORDS   = 4;
    localparam int STAT_OFS    = 16;

    // Event bundle for one channel; bit order matches the slot layout.
    typedef struct packed {
        logic list_done;
        logic desc_done;
        logic half_done;
    } evt_t;

    function automatic logic [SLOT_W-1:0] to_slot(evt_t e);
        return {1'b0, e};
    endfunction

    function automatic evt_t from_slot(logic [SLOT_W-1:0] s);
        return evt_t'(s[EVT_W-1:0]);
    endfunction

endpackage

// File: rtl/irq_chan_slot.sv
module irq_chan_slot
    import irq_bank_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_we,
    input  logic st_we,
    input  evt_t wr_bits,
    input  evt_t ev,
    output evt_t en_q,
    output evt_t st_q
);

    evt_t clr_mask;

    always_comb begin
        clr_mask = st_we ? wr_bits : evt_t'('0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (en_we) begin
                en_q <= wr_bits;
            end
            // pulse after the clear so a coinciding event keeps the bit
            st_q <= evt_t'((st_q & ~clr_mask) | ev);
        end
    end

endmodule

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 2
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    output logic [NUM_WORDS-1:0] en_rsel,
    output logic [NUM_WORDS-1:0] st_rsel,
    output logic [NUM_WORDS-1:0] en_wsel,
    output logic [NUM_WORDS-1:0] st_wsel
);

    logic       in_map;
    logic [1:0] widx;

    always_comb begin
        in_map = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:5] == '0);
        widx   = addr[3:2];
    end

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        always_comb begin
            en_rsel[k] = in_map && !addr[4] && (widx == 2'(k));
            st_rsel[k] = in_map &&  addr[4] && (widx == 2'(k));
            en_wsel[k] = en_rsel[k] && wr;
            st_wsel[k] = st_rsel[k] && wr;
        end
    end

endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
    parameter int N = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] st,
    input  logic [N-1:0] en,
    output logic         irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= |(st & en);
        end
    end

endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank
    import irq_bank_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0] ev_half,
    input  logic [NUM_CH-1:0] ev_desc,
    input  logic [NUM_CH-1:0] ev_list,
    output logic              irq
);

    localparam int NUM_WORDS = (NUM_CH + CH_PER_WORD - 1) / CH_PER_WORD;
    localparam int FLAT_W    = NUM_CH * EVT_W;

    logic [NUM_WORDS-1:0] en_rsel, st_rsel, en_wsel, st_wsel;
    logic [BUS_W-1:0]     en_word [NUM_WORDS];
    logic [BUS_W-1:0]     st_word [NUM_WORDS];
    evt_t                 en_q    [NUM_CH];
    evt_t                 st_q    [NUM_CH];
    logic [FLAT_W-1:0]    en_flat, st_flat;

    irq_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_WORDS(NUM_WORDS)
    ) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .en_rsel(en_rsel),
        .st_rsel(st_rsel),
        .en_wsel(en_wsel),
        .st_wsel(st_wsel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int W = c / CH_PER_WORD;
        localparam int P = c % CH_PER_WORD;
        evt_t ev_c;
        evt_t wbits_c;

        always_comb begin
            ev_c.half_done = ev_half[c];
            ev_c.desc_done = ev_desc[c];
            ev_c.list_done = ev_list[c];
            wbits_c        = from_slot(bus_wdata[P*SLOT_W +: SLOT_W]);
        end

        irq_chan_slot u_slot (
            .clk    (clk),
            .rst    (rst),
            .en_we  (en_wsel[W]),
            .st_we  (st_wsel[W]),
            .wr_bits(wbits_c),
            .ev     (ev_c),
            .en_q   (en_q[c]),
            .st_q   (st_q[c])
        );

        assign en_flat[c*EVT_W +: EVT_W] = en_q[c];
        assign st_flat[c*EVT_W +: EVT_W] = st_q[c];
    end

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        for (genvar j = 0; j < CH_PER_WORD; j++) begin : g_nib
            if (k * CH_PER_WORD + j < NUM_CH) begin : g_used
                assign en_word[k][j*SLOT_W +: SLOT_W] = to_slot(en_q[k*CH_PER_WORD+j]);
                assign st_word[k][j*SLOT_W +: SLOT_W] = to_slot(st_q[k*CH_PER_WORD+j]);
            end else begin : g_empty
                assign en_word[k][j*SLOT_W +: SLOT_W] = '0;
                assign st_word[k][j*SLOT_W +: SLOT_W] = '0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (en_rsel[k]) bus_rdata = bus_rdata | en_word[k];
            if (st_rsel[k]) bus_rdata = bus_rdata | st_word[k];
        end
    end

    irq_out_reg #(
        .N(FLAT_W)
    ) u_irq (
        .clk(clk),
        .rst(rst),
        .st (st_flat),
        .en (en_flat),
        .irq(irq)
    );

endmodule

// File: rtl/irq_event_bank_chk.sv
module irq_event_bank_chk #(
    parameter int NUM_CH = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_wr,
    input logic [31:0]         bus_rdata,
    input logic [NUM_CH-1:0]   ev_half,
    input logic [NUM_CH-1:0]   ev_desc,
    input logic [NUM_CH-1:0]   ev_list,
    input logic [NUM_CH*3-1:0] st_flat,
    input logic [NUM_CH*3-1:0] en_flat,
    input logic                irq
);

    // R6: interrupt level follows last cycle's masked pending state
    p_irq_level_r6: assert property (@(posedge clk) disable iff (rst)
        irq == $past(|(st_flat & en_flat)));

    // R8: reserved slot bits never read as one
    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & 32'h8888_8888) == 32'h0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        // R3 and R5: a pulse always leaves its bit set
        p_half_sets_r3: assert property (@(posedge clk) disable iff (rst)
            ev_half[c] |=> st_flat[c*3]);
        p_desc_sets_r5: assert property (@(posedge clk) disable iff (rst)
            ev_desc[c] |=> st_flat[c*3+1]);
        p_list_sets_r3: assert property (@(posedge clk) disable iff (rst)
            ev_list[c] |=> st_flat[c*3+2]);
        // R9: a status bit only rises after its own event
        p_half_rise_r9: assert property (@(posedge clk) disable iff (rst)
            $rose(st_flat[c*3]) |-> $past(ev_half[c]));
        // R4: a status bit only falls after a bus write
        p_half_fall_r4: assert property (@(posedge clk) disable iff (rst)
            $fell(st_flat[c*3]) |-> $past(bus_wr));
        p_list_fall_r4: assert property (@(posedge clk) disable iff (rst)
            $fell(st_flat[c*3+2]) |-> $past(bus_wr));
    end

endmodule

bind irq_event_bank irq_event_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rdata(bus_rdata),
    .ev_half  (ev_half),
    .ev_desc  (ev_desc),
    .ev_list  (ev_list),
    .st_flat  (st_flat),
    .en_flat  (en_flat),
    .irq      (irq)
);

// File: tb/test_irq_event_bank.sv
module test_irq_event_bank;

    localparam int NCH = 12;
    localparam int AW  = 8;

    localparam logic [7:0] EN0 = 8'h00, EN1 = 8'h04, EN2 = 8'h08;
    localparam logic [7:0] ST0 = 8'h10, ST1 = 8'h14;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [AW-1:0]  bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] ev_half = '0, ev_desc = '0, ev_list = '0;
    logic           irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_event_bank #(.NUM_CH(NCH), .ADDR_W(AW)) i_irq_event_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_half(ev_half),
        .ev_desc(ev_desc), .ev_list(ev_list), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_ev(int ch, int kind);
        case (kind)
            0: ev_half[ch] = 1'b1;
            1: ev_desc[ch] = 1'b1;
            default: ev_list[ch] = 1'b1;
        endcase
    endtask

    task automatic pulse(int ch, int kind);
        @(negedge clk);
        set_ev(ch, kind);
        @(negedge clk);
        ev_half = '0; ev_desc = '0; ev_list = '0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 irq", 32'(irq), 32'h0);
        rd_chk("R1 en0", EN0, 32'h0);
        rd_chk("R1 en1", EN1, 32'h0);
        rd_chk("R1 st0", ST0, 32'h0);
        rd_chk("R1 st1", ST1, 32'h0);
    endtask

    task automatic t_map;
        pulse(5, 1);
        rd_chk("R2 ch5 desc", ST0, 32'h0020_0000);
        pulse(10, 2);
        rd_chk("R2 ch10 list", ST1, 32'h0000_0400);
        pulse(0, 0);
        rd_chk("R3 ch0 half", ST0, 32'h0020_0001);
        @(negedge clk);
        check("R3 masked irq", 32'(irq), 32'h0);
    endtask

    task automatic t_clear;
        wr(ST0, 32'h0);
        rd_chk("R4 zero write", ST0, 32'h0020_0001);
        wr(ST0, 32'h0020_0000);
        rd_chk("R4 partial", ST0, 32'h0000_0001);
        pulse(10, 0);
        wr(ST1, 32'h0000_0400);
        rd_chk("R4 st1", ST1, 32'h0000_0100);
        wr(ST1, 32'hFFFF_FFFF);
        wr(ST0, 32'hFFFF_FFFF);
        rd_chk("R4 all st0", ST0, 32'h0);
        rd_chk("R4 all st1", ST1, 32'h0);
    endtask

    task automatic t_enable_irq;
        wr(EN0, 32'hFFFF_FFFF);
        rd_chk("R10 en0", EN0, 32'h7777_7777);
        wr(EN1, 32'hFFFF_FFFF);
        rd_chk("R8 en1 upper", EN1, 32'h0000_7777);
        wr(EN1, 32'h0000_0124);
        rd_chk("R10 en1", EN1, 32'h0000_0124);
        pulse(3, 0);
        check("R6 not yet", 32'(irq), 32'h0);
        @(negedge clk);
        check("R6 rises", 32'(irq), 32'h1);
        wr(ST0, 32'h0000_1000);
        check("R6 still", 32'(irq), 32'h1);
        @(negedge clk);
        check("R6 falls", 32'(irq), 32'h0);
        pulse(9, 0);
        @(negedge clk);
        check("R6 ch9 masked", 32'(irq), 32'h0);
        pulse(8, 2);
        @(negedge clk);
        check("R6 ch8 enabled", 32'(irq), 32'h1);
        wr(ST1, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R6 cleared", 32'(irq), 32'h0);
    endtask

    task automatic t_event_wins;
        pulse(0, 0);
        pulse(1, 0);
        @(negedge clk);
        bus_addr = ST0; bus_wdata = 32'h0000_0011; bus_wr = 1'b1;
        ev_half[1] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ev_half = '0;
        rd_chk("R5 event wins", ST0, 32'h0000_0010);
        wr(ST0, 32'h0000_0010);
        rd_chk("R5 then clears", ST0, 32'h0);
    endtask

    task automatic t_disable;
        pulse(2, 1);
        @(negedge clk);
        check("R7 pre", 32'(irq), 32'h1);
        wr(EN0, 32'h0);
        wr(EN1, 32'h0);
        check("R7 low", 32'(irq), 32'h0);
        pulse(6, 2);
        pulse(11, 1);
        @(negedge clk);
        @(negedge clk);
        check("R7 stays low", 32'(irq), 32'h0);
        rd_chk("R3 st0 kept", ST0, 32'h0400_0200);
        rd_chk("R3 st1 kept", ST1, 32'h0000_2000);
    endtask

    task automatic t_ignored;
        wr(ST0, 32'hFFFF_FFFF);
        wr(ST1, 32'hFFFF_FFFF);
        wr(ST0, 32'hFFFF_FFFF);
        rd_chk("R9 no set st0", ST0, 32'h0);
        rd_chk("R9 no set st1", ST1, 32'h0);
        wr(EN0, 32'h0000_0005);
        wr(8'h02, 32'hFFFF_FFFF);
        rd_chk("R9 unaligned", EN0, 32'h0000_0005);
        wr(8'h20, 32'hFFFF_FFFF);
        rd_chk("R9 out of map", EN0, 32'h0000_0005);
        wr(EN2, 32'hFFFF_FFFF);
        rd_chk("R8 empty word", EN2, 32'h0);
        wr(EN0, 32'h8888_8888);
        rd_chk("R8 reserved", EN0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        @(negedge clk);
        rd_chk("R1 after release", ST0, 32'h0);
        t_map;
        t_clear;
        t_enable_irq;
        t_event_wins;
        t_disable;
        t_ignored;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule